// File: doc/BRIEF.md
# DRAM Command Decoder with Mode Tracking

This block sits behind the input registers of a DRAM device model or memory-side monitor. On every rising clock edge it takes the sampled control pins (chip select, row strobe, column strobe, write enable, clock enable) and turns them into a one-hot command word. That word is registered, so it appears one clock after the pins are sampled. An illegal-command flag is raised alongside it whenever the pin pattern is not allowed in the current state.

The meaning of a pattern depends on two pieces of state that the block keeps itself. The first is whether a read burst is still running. Burst stop is only accepted during a read burst. The second is whether the device is in self refresh. While it is, only the clock-enable pin matters, and only certain patterns may bring the device out. The refresh pattern means auto refresh when clock enable is high and self-refresh entry when it is low.

A burst starts either from a decoded read command or from a separate read-start pulse. It lasts half the programmed burst length, counted in clock cycles.

Top module: `dram_cmd_decoder`

## Requirements
- R1: While reset is held, and for the two clocks after it is released, `cmd_onehot` equals the deselect bit (bit 0), and `illegal_cmd`, `in_self_refresh` and `burst_active` are 0.
- R2: Exactly one bit of `cmd_onehot` is high in every cycle. Outputs reflect the pins sampled at the previous rising edge. Bit map: 0 deselect, 1 nop, 2 activate, 3 read, 4 write, 5 precharge, 6 mode-register-set, 7 auto refresh, 8 self-refresh entry, 9 self-refresh exit, 10 burst stop, 11 self-refresh hold.
- R3: Outside self refresh, `cs_n`=1 decodes as deselect whatever the other pins are, and it changes no state.
- R4: With `cs_n`=0 outside self refresh, {ras_n,cas_n,we_n} decodes as follows: 111 nop, 011 activate, 101 read, 100 write, 010 precharge, 000 mode-register-set.
- R5: Pattern 001 with `cke`=1 decodes as auto refresh. With `cke`=0 it decodes as self-refresh entry, which sets `in_self_refresh` and ends any running burst.
- R6: In self refresh with `cke`=0, the output is the hold bit and every other input, `rd_start` included, is ignored.
- R7: In self refresh with `cke`=1, the block decodes self-refresh exit and clears `in_self_refresh` if `cs_n`=1, or if `ras_n`=1 and `cas_n`=1. Any other pattern gives the hold bit with `illegal_cmd`=1, and the block stays in self refresh.
- R8: A read command or an `rd_start` pulse outside self refresh holds `burst_active` high for max(1, `burst_len`/2) cycles, starting the next cycle. A new start reloads the count.
- R9: Pattern 110 while `burst_active` is 1 decodes as burst stop and clears `burst_active` the next cycle. While `burst_active` is 0 it decodes as nop with `illegal_cmd`=1 and changes no state.
- R10: `illegal_cmd` is high only in the two cases of R7 and R9.
- R11: If `rd_start` and a legal burst stop arrive in the same cycle, the burst reloads. If `rd_start` and self-refresh entry arrive in the same cycle, the burst is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| burst_len | input | BL_W (4) | Programmed burst length |
| rd_start | input | 1 | Read-start pulse |
| cmd_onehot | output | NCMD (12) | Registered one-hot command |
| illegal_cmd | output | 1 | Pattern not allowed in current state |
| in_self_refresh | output | 1 | Self-refresh status |
| burst_active | output | 1 | Read burst in progress |

## Verification
The checker tests these properties on every cycle:
- the one-hot property of the command word;
- that a burst stop is only decoded after a cycle with an active burst;
- that self-refresh status rises only with an entry decode and falls only with an exit decode;
- that the hold bit appears only while in self refresh;
- that the illegal flag only comes with the nop or hold bits.

The exact burst duration for each burst length, the reload priorities and the full pattern table need the bench's reference model. So does the fact that junk inputs in self refresh are ignored. The model replays directed and random pin sequences against all of these.

// File: rtl/dram_cmd_pkg.sv
package dram_cmd_pkg;
  localparam int NCMD = 12;

  // Bit positions in the one-hot command word
  localparam int B_DESEL  = 0;
  localparam int B_NOP    = 1;
  localparam int B_ACT    = 2;
  localparam int B_READ   = 3;
  localparam int B_WRITE  = 4;
  localparam int B_PRE    = 5;
  localparam int B_MRS    = 6;
  localparam int B_AREF   = 7;
  localparam int B_SRE    = 8;
  localparam int B_SRX    = 9;
  localparam int B_BST    = 10;
  localparam int B_SRHOLD = 11;

  typedef enum logic [2:0] {
    PAT_MRS = 3'b000,
    PAT_REF = 3'b001,
    PAT_PRE = 3'b010,
    PAT_ACT = 3'b011,
    PAT_WR  = 3'b100,
    PAT_RD  = 3'b101,
    PAT_BST = 3'b110,
    PAT_NOP = 3'b111
  } pin_pat_e;
endpackage

// File: rtl/dram_rst_sync.sv
module dram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/dram_pin_pattern.sv
module dram_pin_pattern
  import dram_cmd_pkg::*;
(
  input  logic     ras_n,
  input  logic     cas_n,
  input  logic     we_n,
  output pin_pat_e pat,
  output logic     nop_like
);
  always_comb begin
    pat      = pin_pat_e'({ras_n, cas_n, we_n});
    nop_like = ras_n & cas_n;
  end
endmodule

// File: rtl/dram_burst_track.sv
module dram_burst_track #(
  parameter int BL_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            stop,
  input  logic            flush,
  input  logic [BL_W-1:0] burst_len,
  output logic            active
);
  localparam int CNT_W = (BL_W > 1) ? BL_W - 1 : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, half_len;

  always_comb begin
    half_len = CNT_W'(burst_len >> 1);
    if (half_len == '0) half_len = CNT_W'(1);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (flush)              cnt_d = '0;
    else if (load)          cnt_d = half_len;
    else if (stop)          cnt_d = '0;
    else if (cnt_q != '0)   cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/dram_selfref_track.sv
module dram_selfref_track (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  logic leave,
  output logic in_sr
);
  logic sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (enter)      sr_d = 1'b1;
    else if (leave) sr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 1'b0;
    else        sr_q <= sr_d;
  end

  assign in_sr = sr_q;
endmodule

// File: rtl/dram_cmd_decoder.sv
module dram_cmd_decoder
  import dram_cmd_pkg::*;
#(
  parameter int BL_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic            cke,
  input  logic [BL_W-1:0] burst_len,
  input  logic            rd_start,
  output logic [NCMD-1:0] cmd_onehot,
  output logic            illegal_cmd,
  output logic            in_self_refresh,
  output logic            burst_active
);
  localparam int SEL_W = $clog2(NCMD);

  logic            rst_n_sync;
  pin_pat_e        pat;
  logic            nop_like;
  logic [SEL_W-1:0] sel_d;
  logic            ill_d;
  logic            sr_enter, sr_leave;
  logic            b_load, b_stop;
  logic [NCMD-1:0] onehot_d;
  logic [NCMD-1:0] cmd_q;
  logic            ill_q;

  dram_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  dram_pin_pattern u_pat (
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .pat      (pat),
    .nop_like (nop_like)
  );

  dram_selfref_track u_sr (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .enter (sr_enter),
    .leave (sr_leave),
    .in_sr (in_self_refresh)
  );

  dram_burst_track #(.BL_W(BL_W)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .load      (b_load),
    .stop      (b_stop),
    .flush     (sr_enter),
    .burst_len (burst_len),
    .active    (burst_active)
  );

  // Next-state decode: pins + current mode state -> command index
  always_comb begin
    sel_d    = SEL_W'(B_DESEL);
    ill_d    = 1'b0;
    sr_enter = 1'b0;
    sr_leave = 1'b0;
    b_load   = 1'b0;
    b_stop   = 1'b0;
    if (in_self_refresh) begin
      if (!cke) begin
        sel_d = SEL_W'(B_SRHOLD);
      end else if (cs_n || nop_like) begin
        sel_d    = SEL_W'(B_SRX);
        sr_leave = 1'b1;
      end else begin
        sel_d = SEL_W'(B_SRHOLD);
        ill_d = 1'b1;
      end
    end else begin
      b_load = rd_start;
      if (cs_n) begin
        sel_d = SEL_W'(B_DESEL);
      end else begin
        unique case (pat)
          PAT_NOP: sel_d = SEL_W'(B_NOP);
          PAT_ACT: sel_d = SEL_W'(B_ACT);
          PAT_RD: begin
            sel_d  = SEL_W'(B_READ);
            b_load = 1'b1;
          end
          PAT_WR:  sel_d = SEL_W'(B_WRITE);
          PAT_PRE: sel_d = SEL_W'(B_PRE);
          PAT_MRS: sel_d = SEL_W'(B_MRS);
          PAT_REF: begin
            if (cke) begin
              sel_d = SEL_W'(B_AREF);
            end else begin
              sel_d    = SEL_W'(B_SRE);
              sr_enter = 1'b1;
            end
          end
          PAT_BST: begin
            if (burst_active) begin
              sel_d  = SEL_W'(B_BST);
              b_stop = 1'b1;
            end else begin
              sel_d = SEL_W'(B_NOP);
              ill_d = 1'b1;
            end
          end
          default: sel_d = SEL_W'(B_NOP);
        endcase
      end
    end
  end

  generate
    for (genvar gi = 0; gi < NCMD; gi++) begin : g_onehot
      assign onehot_d[gi] = (sel_d == SEL_W'(gi));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      cmd_q <= NCMD'(1) << B_DESEL;
      ill_q <= 1'b0;
    end else begin
      cmd_q <= onehot_d;
      ill_q <= ill_d;
    end
  end

  assign cmd_onehot  = cmd_q;
  assign illegal_cmd = ill_q;
endmodule

// File: rtl/dram_cmd_decoder_chk.sv
module dram_cmd_decoder_chk
  import dram_cmd_pkg::*;
(
  input logic            clk,
  input logic            rst_n_sync,
  input logic [NCMD-1:0] cmd_onehot,
  input logic            illegal_cmd,
  input logic            in_self_refresh,
  input logic            burst_active
);
  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $countones(cmd_onehot) == 1);

  assert_bst_needs_burst_R9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    cmd_onehot[B_BST] |-> $past(burst_active));

  assert_sr_rise_R5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(in_self_refresh) |-> cmd_onehot[B_SRE]);

  assert_sr_fall_R7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $fell(in_self_refresh) |-> cmd_onehot[B_SRX]);

  assert_hold_in_sr_R6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    cmd_onehot[B_SRHOLD] |-> in_self_refresh);

  assert_illegal_kind_R10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    illegal_cmd |-> (cmd_onehot[B_NOP] || cmd_onehot[B_SRHOLD]));

  assert_sre_kills_burst_R11: assert property (@(posedge clk) disable iff (!rst_n_sync)
    cmd_onehot[B_SRE] |-> !burst_active);
endmodule

bind dram_cmd_decoder dram_cmd_decoder_chk u_chk (
  .clk             (clk),
  .rst_n_sync      (rst_n_sync),
  .cmd_onehot      (cmd_onehot),
  .illegal_cmd     (illegal_cmd),
  .in_self_refresh (in_self_refresh),
  .burst_active    (burst_active)
);

// File: tb/tb_dram_cmd_decoder.sv
`timescale 1ns/1ps
module tb_dram_cmd_decoder;
  localparam int BL_W = 4;
  localparam int NC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic [BL_W-1:0] burst_len = 4'd8;
  logic rd_start = 1'b0;
  logic [NC-1:0] cmd_onehot;
  logic illegal_cmd, in_self_refresh, burst_active;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  int m_rem = 0;
  bit m_sr = 0;
  int e_cmd = 0;
  bit e_ill = 0;

  always #2 clk = ~clk;

  dram_cmd_decoder #(.BL_W(BL_W)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .burst_len(burst_len), .rd_start(rd_start),
    .cmd_onehot(cmd_onehot), .illegal_cmd(illegal_cmd),
    .in_self_refresh(in_self_refresh), .burst_active(burst_active)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk(cmd_onehot == (12'(1) << e_cmd), tag, "cmd", int'(cmd_onehot), 1 << e_cmd);
    chk(illegal_cmd == e_ill, tag, "illegal", illegal_cmd, e_ill);
    chk(in_self_refresh == m_sr, tag, "in_sr", in_self_refresh, m_sr);
    chk(burst_active == (m_rem > 0), tag, "burst", burst_active, m_rem > 0);
  endtask

  // Behavioural model of one clock
  task automatic model(input bit c, input bit r, input bit a, input bit w,
                       input bit k, input bit rd, input int bl);
    int half;
    bit load, stop, flush;
    half = (bl / 2 == 0) ? 1 : bl / 2;
    load = 0; stop = 0; flush = 0; e_ill = 0;
    if (m_sr) begin
      if (!k) e_cmd = 11;
      else if (c || (r && a)) begin e_cmd = 9; m_sr = 0; end
      else begin e_cmd = 11; e_ill = 1; end
    end else begin
      load = rd;
      if (c) e_cmd = 0;
      else case ({r, a, w})
        3'b111: e_cmd = 1;
        3'b011: e_cmd = 2;
        3'b101: begin e_cmd = 3; load = 1; end
        3'b100: e_cmd = 4;
        3'b010: e_cmd = 5;
        3'b000: e_cmd = 6;
        3'b001: if (k) e_cmd = 7; else begin e_cmd = 8; m_sr = 1; flush = 1; end
        default: if (m_rem > 0) begin e_cmd = 10; stop = 1; end
                 else begin e_cmd = 1; e_ill = 1; end
      endcase
    end
    if (flush) m_rem = 0;
    else if (load) m_rem = half;
    else if (stop) m_rem = 0;
    else if (m_rem > 0) m_rem--;
  endtask

  task automatic cyc(input bit c, input bit r, input bit a, input bit w,
                     input bit k, input bit rd, input string tag);
    cs_n = c; ras_n = r; cas_n = a; we_n = w; cke = k; rd_start = rd;
    model(c, r, a, w, k, rd, int'(burst_len));
    @(posedge clk); #1;
    compare(tag);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    e_cmd = 0;
    repeat (3) @(posedge clk);
    #1 compare("R1 in reset");
    rst_n = 1'b1;
    // two synchroniser clocks: outputs stay at reset values
    for (int i = 0; i < 2; i++) begin
      @(posedge clk); #1; compare("R1 after release");
    end
    // R3 deselect ignores other pins
    cyc(1, 0, 0, 0, 1, 0, "R3");
    cyc(1, 1, 1, 0, 1, 0, "R3");
    // R4 table
    cyc(0, 1, 1, 1, 1, 0, "R4 nop");
    cyc(0, 0, 1, 1, 1, 0, "R4 act");
    cyc(0, 1, 0, 0, 1, 0, "R4 write");
    cyc(0, 0, 1, 0, 1, 0, "R4 pre");
    cyc(0, 0, 0, 0, 1, 0, "R4 mrs");
    // R8 read bl=8 -> 4 cycles
    burst_len = 4'd8;
    cyc(0, 1, 0, 1, 1, 0, "R8 read");
    for (int i = 0; i < 5; i++) cyc(0, 1, 1, 1, 1, 0, "R8 countdown");
    // R9 burst stop outside burst
    cyc(0, 1, 1, 0, 1, 0, "R9 illegal bst");
    cyc(0, 1, 1, 1, 1, 0, "R10 flag clears");
    // R9 legal burst stop
    cyc(0, 1, 0, 1, 1, 0, "R8 read");
    cyc(0, 1, 1, 1, 1, 0, "R8");
    cyc(0, 1, 1, 0, 1, 0, "R9 bst");
    cyc(0, 1, 1, 1, 1, 0, "R9 after");
    // short lengths
    burst_len = 4'd2;
    cyc(1, 1, 1, 1, 1, 1, "R8 rd_start bl2");
    cyc(1, 1, 1, 1, 1, 0, "R8 bl2");
    burst_len = 4'd0;
    cyc(0, 1, 0, 1, 1, 0, "R8 bl0");
    cyc(0, 1, 1, 1, 1, 0, "R8 bl0");
    // R11 rd_start with legal bst reloads
    burst_len = 4'd4;
    cyc(0, 1, 0, 1, 1, 0, "R8 read bl4");
    cyc(0, 1, 1, 0, 1, 1, "R11 reload");
    cyc(0, 1, 1, 1, 1, 0, "R11");
    cyc(0, 1, 1, 1, 1, 0, "R11");
    // R5 auto refresh, then self refresh entry during burst with rd_start
    cyc(0, 0, 0, 1, 1, 0, "R5 aref");
    burst_len = 4'd8;
    cyc(0, 1, 0, 1, 1, 0, "R8 read");
    cyc(0, 0, 0, 1, 0, 1, "R11 sre flush");
    // R6 junk while in self refresh
    cyc(0, 1, 0, 1, 0, 1, "R6 ignore");
    cyc(1, 0, 0, 0, 0, 1, "R6 ignore");
    // R7 bad exit, then exit via nop pattern with WE low
    cyc(0, 0, 1, 1, 1, 0, "R7 bad exit");
    cyc(0, 1, 1, 0, 1, 0, "R7 exit nop");
    cyc(0, 1, 1, 1, 1, 0, "R7 after");
    // exit via CS high
    cyc(0, 0, 0, 1, 0, 0, "R5 sre");
    cyc(1, 0, 0, 0, 1, 0, "R7 exit cs");
    // random
    for (int i = 0; i < 2000; i++) begin
      burst_len = 4'($urandom_range(0, 15));
      cyc(1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom),
          1'($urandom), 1'($urandom_range(0, 7) != 0),
          1'($urandom_range(0, 7) == 0), "R2 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule